// File: doc/BRIEF.md
# Byte-Sliced Registered Bus Transceiver

This block joins two 16-bit buses, A and B, built as two independent 8-bit slices. Each slice has an active-low output enable, a direction control, a capture clock for each direction and a source select for each direction. Each slice holds one storage register that captures the A bus and one that captures the B bus. When a slice drives a bus, it drives either the live value from the other bus or the value held in the matching register. Data lanes do not invert.

Bus pins are modelled as separate input, output and output-enable vectors on each side, so a pad ring or tri-state wrapper can be placed outside the block. The two slices share only the register reset. Each slice's controls can be tied together to get full 16-bit operation.

Top module: `dual_byte_xcvr`

## Requirements
- R1: While `enN[s]` is 1, slice s asserts none of its bits in `aOe` or `bOe`.
- R2: With `enN[s]` at 0, `dirToB[s]`=1 sets all eight bits of slice s in `bOe` and clears them in `aOe`. `dirToB[s]`=0 does the reverse. `aOe` and `bOe` are never both set for the same lane.
- R3: When slice s drives B with `selStoredAB[s]`=0, its lanes of `bOut` equal its lanes of `aIn` in the same cycle.
- R4: When slice s drives A with `selStoredBA[s]`=0, its lanes of `aOut` equal its lanes of `bIn` in the same cycle.
- R5: When slice s drives B with `selStoredAB[s]`=1, its lanes of `bOut` show the slice's A-capture register and do not follow `aIn`.
- R6: When slice s drives A with `selStoredBA[s]`=1, its lanes of `aOut` show the slice's B-capture register and do not follow `bIn`.
- R7: On each rising edge of `capA[s]` with `rstN`=1, the A-capture register of slice s loads that slice's lanes of `aIn`. This happens whatever the values of `enN` and `dirToB`.
- R8: On each rising edge of `capB[s]` with `rstN`=1, the B-capture register of slice s loads that slice's lanes of `bIn`. This happens whatever the values of `enN` and `dirToB`.
- R9: In stored mode, a capture edge on the driving direction makes the output show the newly captured value from that edge onward.
- R10: Slice 0 (lanes 7:0) and slice 1 (lanes 15:8) act independently. Each slice follows only its own control bits.
- R11: A rising capture edge with `rstN`=0 clears that register to zero.
- R12: On each side, the lanes of a slice that is not driving that side read 0 on the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Synchronous active-low clear, applied on capture edges |
| enN | input | 2 | Per-slice active-low output enable |
| dirToB | input | 2 | Per-slice direction: 1 drives B, 0 drives A |
| selStoredAB | input | 2 | Per-slice B-side source: 0 live A, 1 stored A |
| selStoredBA | input | 2 | Per-slice A-side source: 0 live B, 1 stored B |
| capA | input | 2 | Per-slice rising-edge capture clock for the A register |
| capB | input | 2 | Per-slice rising-edge capture clock for the B register |
| aIn | input | 16 | A bus as received |
| aOut | output | 16 | Data driven onto the A bus |
| aOe | output | 16 | Per-lane A bus drive enable |
| bIn | input | 16 | B bus as received |
| bOut | output | 16 | Data driven onto the B bus |
| bOe | output | 16 | Per-lane B bus drive enable |

## Verification
Assertions in the RTL check the following on every evaluation:
- the two sides never drive the same lane at once;
- an isolated slice drives nothing;
- transparent lanes equal the opposite input;
- idle data outputs stay at zero;
- each register holds what its previous capture edge sampled.

Some behaviour can only be shown by the bench's scenarios, because it depends on a history of edges and control changes. This covers loading while the slice is isolated and reading the value back later in stored mode, the output switching to new data right at the capture edge, the clear-on-edge reset, and the two slices running with different controls. The bench's behavioural model also covers random sequences of edges and control changes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Per-slice strobes from the control decode to the datapath
  typedef struct packed {
    logic driveA;     // slice drives the A side
    logic driveB;     // slice drives the B side
    logic storedToA;  // A side shows the B-capture register
    logic storedToB;  // B side shows the A-capture register
  } slice_ctl_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int SLICES = 2
) (
  input  logic                    rstN,
  input  logic [SLICES-1:0]       enN,
  input  logic [SLICES-1:0]       dirToB,
  input  logic [SLICES-1:0]       selStoredAB,
  input  logic [SLICES-1:0]       selStoredBA,
  output slice_ctl_t [SLICES-1:0] ctl
);

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    always_comb begin
      ctl[s].driveB    = !enN[s] && dirToB[s];
      ctl[s].driveA    = !enN[s] && !dirToB[s];
      ctl[s].storedToB = selStoredAB[s];
      ctl[s].storedToA = selStoredBA[s];
    end

    // R1 and R2: isolation and exclusive direction
    always_comb begin
      if (rstN) begin
        p_isolate_r1: assert (!(enN[s] && (ctl[s].driveA || ctl[s].driveB)))
          else $error("slice %0d drives while disabled", s);
        p_one_side_r2: assert (!(ctl[s].driveA && ctl[s].driveB))
          else $error("slice %0d drives both sides", s);
      end
    end
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int SLICES = 2,
  localparam int BUS_W = LANE_W * SLICES
) (
  input  logic                    rstN,
  input  logic [SLICES-1:0]       capA,
  input  logic [SLICES-1:0]       capB,
  input  slice_ctl_t [SLICES-1:0] ctl,
  input  logic [BUS_W-1:0]        aIn,
  input  logic [BUS_W-1:0]        bIn,
  output logic [BUS_W-1:0]        aOut,
  output logic [BUS_W-1:0]        aOe,
  output logic [BUS_W-1:0]        bOut,
  output logic [BUS_W-1:0]        bOe
);

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [LANE_W-1:0] heldA;
    logic [LANE_W-1:0] heldB;
    logic [LANE_W-1:0] liveA;
    logic [LANE_W-1:0] liveB;

    assign liveA = aIn[s*LANE_W +: LANE_W];
    assign liveB = bIn[s*LANE_W +: LANE_W];

    // A-capture register, own clock domain
    always_ff @(posedge capA[s]) begin
      if (!rstN) heldA <= '0;
      else       heldA <= liveA;
    end

    // B-capture register, own clock domain
    always_ff @(posedge capB[s]) begin
      if (!rstN) heldB <= '0;
      else       heldB <= liveB;
    end

    // Output multiplexers
    always_comb begin
      bOe[s*LANE_W +: LANE_W]  = {LANE_W{ctl[s].driveB}};
      aOe[s*LANE_W +: LANE_W]  = {LANE_W{ctl[s].driveA}};
      bOut[s*LANE_W +: LANE_W] = '0;
      aOut[s*LANE_W +: LANE_W] = '0;
      if (ctl[s].driveB)
        bOut[s*LANE_W +: LANE_W] = ctl[s].storedToB ? heldA : liveA;
      if (ctl[s].driveA)
        aOut[s*LANE_W +: LANE_W] = ctl[s].storedToA ? heldB : liveB;
    end

    // R7 and R8: each register holds what its previous edge sampled
    p_capture_a_r7: assert property (@(posedge capA[s]) disable iff (!rstN)
      1'b1 |=> heldA == $past(liveA))
      else $error("slice %0d A register lost its capture", s);
    p_capture_b_r8: assert property (@(posedge capB[s]) disable iff (!rstN)
      1'b1 |=> heldB == $past(liveB))
      else $error("slice %0d B register lost its capture", s);

    // R3, R4, R12: transparent paths and idle outputs
    always_comb begin
      if (rstN) begin
        p_live_ab_r3: assert (!(bOe[s*LANE_W] && !ctl[s].storedToB) ||
                              bOut[s*LANE_W +: LANE_W] == aIn[s*LANE_W +: LANE_W])
          else $error("slice %0d B side not transparent", s);
        p_live_ba_r4: assert (!(aOe[s*LANE_W] && !ctl[s].storedToA) ||
                              aOut[s*LANE_W +: LANE_W] == bIn[s*LANE_W +: LANE_W])
          else $error("slice %0d A side not transparent", s);
        p_idle_zero_r12: assert ((bOe[s*LANE_W] || bOut[s*LANE_W +: LANE_W] == '0) &&
                                 (aOe[s*LANE_W] || aOut[s*LANE_W +: LANE_W] == '0))
          else $error("slice %0d idle output not zero", s);
      end
    end
  end

endmodule

// File: rtl/dual_byte_xcvr.sv
module dual_byte_xcvr
  import xcvr_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int SLICES = 2,
  localparam int BUS_W = LANE_W * SLICES
) (
  input  logic              rstN,
  input  logic [SLICES-1:0] enN,
  input  logic [SLICES-1:0] dirToB,
  input  logic [SLICES-1:0] selStoredAB,
  input  logic [SLICES-1:0] selStoredBA,
  input  logic [SLICES-1:0] capA,
  input  logic [SLICES-1:0] capB,
  input  logic [BUS_W-1:0]  aIn,
  output logic [BUS_W-1:0]  aOut,
  output logic [BUS_W-1:0]  aOe,
  input  logic [BUS_W-1:0]  bIn,
  output logic [BUS_W-1:0]  bOut,
  output logic [BUS_W-1:0]  bOe
);

  slice_ctl_t [SLICES-1:0] sliceCtl;

  xcvr_ctrl #(.SLICES(SLICES)) u_ctrl (
    .rstN        (rstN),
    .enN         (enN),
    .dirToB      (dirToB),
    .selStoredAB (selStoredAB),
    .selStoredBA (selStoredBA),
    .ctl         (sliceCtl)
  );

  xcvr_datapath #(.LANE_W(LANE_W), .SLICES(SLICES)) u_dp (
    .rstN (rstN),
    .capA (capA),
    .capB (capB),
    .ctl  (sliceCtl),
    .aIn  (aIn),
    .bIn  (bIn),
    .aOut (aOut),
    .aOe  (aOe),
    .bOut (bOut),
    .bOe  (bOe)
  );

endmodule

// File: tb/dual_byte_xcvr_tb.sv
module dual_byte_xcvr_tb;
  localparam int W = 8;
  localparam int S = 2;
  localparam int BW = W * S;

  logic clk = 1'b0;
  logic rstN;
  logic [S-1:0] enN, dirToB, selAB, selBA, capA, capB;
  logic [BW-1:0] aIn, bIn, aOut, aOe, bOut, bOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int refA [S];
  int refB [S];
  logic [S-1:0] prevA = '0;
  logic [S-1:0] prevB = '0;

  always #10 clk = ~clk;

  dual_byte_xcvr #(.LANE_W(W), .SLICES(S)) u_dut (
    .rstN(rstN), .enN(enN), .dirToB(dirToB), .selStoredAB(selAB),
    .selStoredBA(selBA), .capA(capA), .capB(capB), .aIn(aIn), .aOut(aOut),
    .aOe(aOe), .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Model compared on every clock
  always @(negedge clk) begin
    if (!done) begin
      for (int s = 0; s < S; s++) begin
        int la, lb, eAo, eBo, eAe, eBe;
        la = int'(aIn[s*W +: W]);
        lb = int'(bIn[s*W +: W]);
        if (capA[s] && !prevA[s]) refA[s] = rstN ? la : 0;
        if (capB[s] && !prevB[s]) refB[s] = rstN ? lb : 0;
        eAo = 0; eBo = 0; eAe = 0; eBe = 0;
        if (!enN[s]) begin
          if (dirToB[s]) begin eBe = 8'hFF; eBo = selAB[s] ? refA[s] : la; end
          else           begin eAe = 8'hFF; eAo = selBA[s] ? refB[s] : lb; end
        end
        chk(enN[s] ? "R1 model A oe" : "R2 model A oe", int'(aOe[s*W +: W]), eAe);
        chk(enN[s] ? "R1 model B oe" : "R2 model B oe", int'(bOe[s*W +: W]), eBe);
        chk(eBe == 0 ? "R12 model B out" : (selAB[s] ? "R5 R7 model B out" : "R3 model B out"),
            int'(bOut[s*W +: W]), eBo);
        chk(eAe == 0 ? "R12 model A out" : (selBA[s] ? "R6 R8 model A out" : "R4 model A out"),
            int'(aOut[s*W +: W]), eAo);
      end
      prevA = capA;
      prevB = capB;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [S-1:0] pa, input logic [S-1:0] pb);
    step(); capA = pa; capB = pb;
    step(); capA = '0; capB = '0;
    step();
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < S; s++) begin refA[s] = 0; refB[s] = 0; end
    rstN = 1'b0; enN = '1; dirToB = '1; selAB = '0; selBA = '0;
    capA = '0; capB = '0; aIn = 16'hFFFF; bIn = 16'hFFFF;

    // R11: clear on edges while rstN low
    pulse('1, '1);
    step(); rstN = 1'b1;
    settle();
    chk("R1 reset A oe", int'(aOe), 0);
    chk("R1 reset B oe", int'(bOe), 0);
    chk("R12 reset outputs", int'(aOut | bOut), 0);
    step(); enN = '0; dirToB = '1; selAB = '1;
    settle();
    chk("R11 stored A cleared", int'(bOut), 0);
    step(); dirToB = '0; selBA = '1;
    settle();
    chk("R11 stored B cleared", int'(aOut), 0);

    // R3 and R2: live A to B
    step(); dirToB = '1; selAB = '0; aIn = 16'h5AC3;
    settle();
    chk("R3 live A to B", int'(bOut), 16'h5AC3);
    chk("R2 B oe set", int'(bOe), 16'hFFFF);
    chk("R2 A oe clear", int'(aOe), 0);

    // R4: live B to A
    step(); dirToB = '0; selBA = '0; bIn = 16'h1E77;
    settle();
    chk("R4 live B to A", int'(aOut), 16'h1E77);
    chk("R2 A oe set", int'(aOe), 16'hFFFF);

    // R7 R8: capture while isolated, then read back stored
    step(); enN = '1; aIn = 16'hA1B2; bIn = 16'hC3D4;
    pulse('1, '1);
    settle();
    chk("R1 isolated during capture", int'(aOe | bOe), 0);
    step(); enN = '0; dirToB = '1; selAB = '1; aIn = 16'h0000;
    settle();
    chk("R5 R7 stored A to B", int'(bOut), 16'hA1B2);
    step(); dirToB = '0; selBA = '1; bIn = 16'h0000;
    settle();
    chk("R6 R8 stored B to A", int'(aOut), 16'hC3D4);

    // R9: capture and output in stored mode
    step(); dirToB = '1; selAB = '1; aIn = 16'h0F0F;
    settle();
    chk("R9 before edge", int'(bOut), 16'hA1B2);
    step(); capA = '1;
    settle();
    chk("R9 after edge", int'(bOut), 16'h0F0F);
    step(); capA = '0;

    // R10: slices with different controls
    step(); enN = 2'b10; dirToB = 2'b01; selAB = '0; aIn = 16'h3344;
    settle();
    chk("R10 B out mixed", int'(bOut), 16'h0044);
    chk("R10 B oe mixed", int'(bOe), 16'h00FF);
    step(); enN = 2'b00; selBA = '0; bIn = 16'h9900;
    settle();
    chk("R10 A oe mixed", int'(aOe), 16'hFF00);
    chk("R10 A out mixed", int'(aOut), 16'h9900);

    // Random sequences against the model
    for (int i = 0; i < 2000; i++) begin
      step();
      if ($urandom_range(0, 2) == 0) begin
        capA = '0; capB = '0;
        aIn = 16'($urandom); bIn = 16'($urandom);
        enN = S'($urandom); dirToB = S'($urandom);
        selAB = S'($urandom); selBA = S'($urandom);
        rstN = ($urandom_range(0, 30) != 0);
      end else begin
        capA = S'($urandom); capB = S'($urandom);
      end
    end

    step();
    settle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule